// File: doc/BRIEF.md
# Strobed Byte Input Buffer with Request Flow Control

This block takes a compressed-audio byte stream from a host and holds it in an on-chip FIFO. The host places a byte on an 8-bit bus and raises a data strobe. The rising strobe edge latches the byte into a holding register. The strobe level then passes through a synchronizer into the system clock domain. An edge detector turns the synchronized rise into a single FIFO write. A consumer in the system clock domain drains the FIFO through a show-ahead pop port.

Flow control uses one request line. It rises after every accepted strobe edge. It falls back low one system clock later unless the FIFO has reached its full mark. The full mark is one entry short of capacity, so the host can still send one more byte after it sees the line stay high. A mode input selects the source of FIFO writes. With the mode input low, bytes come from the strobed bus. With it high, bytes come from a serial path that already delivers whole bytes in the system clock domain.

Top module: `byteStrobeBuffer`

## Requirements
- R1: Bytes written into the FIFO leave it through the pop port in the order they were written. `popData` always shows the oldest stored byte.
- R2: With parallel input selected (`serialSel` = 0), a rising edge of `hostStrobe` sets `hostReq` high on the third rising `clk` edge after the strobe rises, whatever the fill level. This is the timing with the default of two synchronizer stages. The strobe must stay high and then low for at least two `clk` periods each.
- R3: While `hostReq` is high and no new strobe edge is detected, `hostReq` goes low on the next `clk` edge if the FIFO holds fewer than DEPTH-1 bytes. It stays high while the FIFO holds DEPTH-1 or more.
- R4: When the fill level is DEPTH-1 (`hostReq` held high), one more strobed byte is still stored, and the fill level reaches DEPTH.
- R5: A byte that arrives while the FIFO holds DEPTH bytes is discarded. It sets `overflowFlag`, which stays set until reset.
- R6: While `serialSel` = 1, strobes on the parallel bus write nothing and do not raise `hostReq`. A `serByteValid` pulse stores `serByte`.
- R7: While `serialSel` = 0, `serByteValid` pulses are ignored.
- R8: `popValid` is high exactly when the FIFO is not empty. `popReq` removes the head byte when `popValid` is high and has no effect on an empty FIFO.
- R9: Reset (`rstN` low) empties the FIFO and drives `hostReq` and `overflowFlag` low.
- R10: After pops take the fill level below DEPTH-1, `hostReq` is low two `clk` edges after the pop edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serialSel | input | 1 | Input path select: 0 = strobed byte bus, 1 = serial byte path |
| hostData | input | 8 | Host byte bus, latched on the rising edge of hostStrobe |
| hostStrobe | input | 1 | Host data strobe, asynchronous to clk |
| serByte | input | 8 | Byte from the serial path |
| serByteValid | input | 1 | One-cycle write strobe for serByte, in the clk domain |
| hostReq | output | 1 | Request / busy line to the host |
| popReq | input | 1 | Consumer request to remove the head byte |
| popData | output | 8 | Head byte of the FIFO (show-ahead) |
| popValid | output | 1 | FIFO holds at least one byte |
| overflowFlag | output | 1 | Sticky flag: a byte was dropped because the FIFO was at capacity |

## Verification
The bench uses a four-entry configuration. It strobes bytes in at every fill level from empty to one past capacity. This separates three cases at the request line: the plain pulse, the held-high full mark, and the extra byte accepted at that mark. It also separates storing a byte from dropping it at overflow. Draining the FIFO one byte at a time shows when the request line falls. Repeated fill and drain rounds with unequal counts move the pointers across the wrap point, which shows whether ordering is kept. Strobes sent in serial mode and serial pulses sent in parallel mode show whether the mode select keeps each path from reaching the FIFO.

// File: rtl/sbufPkg.sv
package sbufPkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic wrEn;      // store one byte this cycle
    logic wrSerial;  // source of the stored byte: 1 = serial path
    logic rdEn;      // advance the read side this cycle
  } bufCtl_t;
endpackage

// File: rtl/sbufSync.sv
module sbufSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/sbufCtrl.sv
module sbufCtrl
  import sbufPkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostStrobe,
  input  logic             serialSel,
  input  logic             serByteValid,
  input  logic             popReq,
  output bufCtl_t          ctl,
  output logic             hostReq,
  output logic             overflowFlag,
  output logic             popValid,
  output logic [CNT_W-1:0] fillCount,
  output logic             parEdge
);
  localparam logic [CNT_W-1:0] FULL_MARK = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP       = CNT_W'(DEPTH);

  logic strobeSync, strobeDly;
  logic serWrite, wrAttempt, isFull, atCap;

  sbufSync #(.STAGES(SYNC_STAGES)) strobeSync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(hostStrobe),
    .syncOut(strobeSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeDly <= 1'b0;
    else       strobeDly <= strobeSync;
  end

  assign parEdge   = strobeSync & ~strobeDly & ~serialSel;
  assign serWrite  = serByteValid & serialSel;
  assign wrAttempt = parEdge | serWrite;
  assign isFull    = fillCount >= FULL_MARK;
  assign atCap     = fillCount == CAP;
  assign popValid  = fillCount != '0;

  always_comb begin
    ctl.wrEn     = wrAttempt & ~atCap;
    ctl.wrSerial = serialSel;
    ctl.rdEn     = popReq & popValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount    <= '0;
      hostReq      <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      case ({ctl.wrEn, ctl.rdEn})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
      hostReq      <= parEdge | (hostReq & isFull);
      overflowFlag <= overflowFlag | (wrAttempt & atCap);
    end
  end
endmodule

// File: rtl/sbufDatapath.sv
module sbufDatapath
  import sbufPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStrobe,
  input  logic [DATA_W-1:0] hostData,
  input  logic [DATA_W-1:0] serByte,
  input  bufCtl_t           ctl,
  output logic [DATA_W-1:0] popData
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] capByte;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // Holding register in the strobe domain; host keeps it stable until written
  always_ff @(posedge hostStrobe) capByte <= hostData;

  assign wrData = ctl.wrSerial ? serByte : capByte;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.wrEn) wrPtr <= stepPtr(wrPtr);
      if (ctl.rdEn) rdPtr <= stepPtr(rdPtr);
    end
  end

  assign popData = mem[rdPtr];
endmodule

// File: rtl/byteStrobeBuffer.sv
module byteStrobeBuffer
  import sbufPkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialSel,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostStrobe,
  input  logic [DATA_W-1:0] serByte,
  input  logic              serByteValid,
  output logic              hostReq,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  output logic              popValid,
  output logic              overflowFlag
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  bufCtl_t          ctl;
  logic [CNT_W-1:0] fillCount;
  logic             parEdge;

  sbufCtrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .hostStrobe  (hostStrobe),
    .serialSel   (serialSel),
    .serByteValid(serByteValid),
    .popReq      (popReq),
    .ctl         (ctl),
    .hostReq     (hostReq),
    .overflowFlag(overflowFlag),
    .popValid    (popValid),
    .fillCount   (fillCount),
    .parEdge     (parEdge)
  );

  sbufDatapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .hostStrobe(hostStrobe),
    .hostData  (hostData),
    .serByte   (serByte),
    .ctl       (ctl),
    .popData   (popData)
  );
endmodule

// File: rtl/byteStrobeBufferChk.sv
module byteStrobeBufferChk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             serialSel,
  input logic             serByteValid,
  input logic             popReq,
  input logic             hostReq,
  input logic             popValid,
  input logic             overflowFlag,
  input logic [CNT_W-1:0] fillCount,
  input logic             parEdge
);
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && fillCount < CNT_W'(DEPTH - 1) && !parEdge) |=> !hostReq);

  p_serial_no_par_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (serialSel && !serByteValid && !popReq) |=> $stable(fillCount));

  p_par_ignores_serial_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!serialSel && !parEdge && !popReq) |=> $stable(fillCount));

  p_valid_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0) |-> !popValid);
endmodule

bind byteStrobeBuffer byteStrobeBufferChk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .serialSel   (serialSel),
  .serByteValid(serByteValid),
  .popReq      (popReq),
  .hostReq     (hostReq),
  .popValid    (popValid),
  .overflowFlag(overflowFlag),
  .fillCount   (fillCount),
  .parEdge     (parEdge)
);

// File: tb/byteStrobeBuffer_tb_top.sv
`timescale 1ns/1ps
module byteStrobeBuffer_tb_top;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serialSel = 1'b0;
  logic [7:0] hostData = '0;
  logic       hostStrobe = 1'b0;
  logic [7:0] serByte = '0;
  logic       serByteValid = 1'b0;
  logic       popReq = 1'b0;
  logic       hostReq, popValid, overflowFlag;
  logic [7:0] popData;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  logic [7:0] q[$];
  bit  reqModel = 0;
  bit  ovfModel = 0;

  always #10 clk = ~clk;

  byteStrobeBuffer #(.DEPTH(D), .DATA_W(8), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .serialSel(serialSel), .hostData(hostData),
    .hostStrobe(hostStrobe), .serByte(serByte), .serByteValid(serByteValid),
    .hostReq(hostReq), .popReq(popReq), .popData(popData),
    .popValid(popValid), .overflowFlag(overflowFlag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic strobeByte(input logic [7:0] b);
    bit par;
    par = !serialSel;
    @(negedge clk);
    hostData = b;
    #1 hostStrobe = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (par) chk(hostReq == 1'b1, "R2 req after strobe", hostReq, 1);
    else     chk(hostReq == reqModel, "R6 req unchanged in serial mode", hostReq, reqModel);
    if (par) begin
      if (q.size() < D) q.push_back(b);
      else ovfModel = 1;
    end
    @(posedge clk);
    @(negedge clk);
    if (par) reqModel = (q.size() >= D - 1);
    chk(hostReq == reqModel, "R3/R4 req after one more clock", hostReq, reqModel);
    chk(popValid == (q.size() > 0), "R1/R4 stored byte visible", popValid, q.size() > 0);
    chk(overflowFlag == ovfModel, "R5 overflow flag", overflowFlag, ovfModel);
    hostStrobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic popOne();
    @(negedge clk);
    chk(popValid == (q.size() > 0), "R8 popValid", popValid, q.size() > 0);
    if (q.size() > 0) chk(popData == q[0], "R1 head byte order", popData, q[0]);
    popReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    popReq = 1'b0;
    if (q.size() > 0) void'(q.pop_front());
    @(posedge clk);
    @(negedge clk);
    reqModel = reqModel && (q.size() >= D - 1);
    chk(hostReq == reqModel, "R10 req after pop", hostReq, reqModel);
  endtask

  task automatic serialPush(input logic [7:0] b);
    @(negedge clk);
    serByte = b;
    serByteValid = 1'b1;
    @(negedge clk);
    serByteValid = 1'b0;
    if (serialSel && q.size() < D) q.push_back(b);
    chk(popValid == (q.size() > 0), serialSel ? "R6 serial byte stored" : "R7 serial byte ignored",
        popValid, q.size() > 0);
    chk(hostReq == reqModel, "R6 serial write leaves req", hostReq, reqModel);
  endtask

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hostReq == 1'b0, "R9 reset req", hostReq, 0);
    chk(popValid == 1'b0, "R9 reset empty", popValid, 0);
    chk(overflowFlag == 1'b0, "R9 reset overflow", overflowFlag, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep every fill level up to one past capacity
    for (int i = 0; i <= D; i++) strobeByte(8'(i * 53 + 7));
    chk(q.size() == D, "R4 headroom byte kept", q.size(), D);
    for (int i = 0; i < D; i++) popOne();
    chk(overflowFlag == 1'b1, "R5 overflow sticky after drain", overflowFlag, 1);

    // Pop on empty has no effect
    popOne();
    strobeByte(8'hA5);
    popOne();

    // Wrap-around rounds with unequal fill and drain
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 3; k++) strobeByte(8'(r * 40 + k * 17 + 1));
      popOne();
      popOne();
    end
    while (q.size() > 0) popOne();

    // Serial mode: strobes ignored, serial bytes stored
    @(negedge clk);
    serialSel = 1'b1;
    strobeByte(8'h3C);
    chk(popValid == 1'b0, "R6 strobe ignored in serial mode", popValid, 0);
    for (int k = 0; k < 3; k++) serialPush(8'(8'hC0 + k));
    while (q.size() > 0) popOne();

    // Parallel mode: serial pulses ignored
    @(negedge clk);
    serialSel = 1'b0;
    serialPush(8'h99);
    serialPush(8'h98);
    chk(popValid == 1'b0, "R7 no serial byte in parallel mode", popValid, 0);
    strobeByte(8'h5A);
    popOne();

    finishRun();
  end
endmodule